// File: doc/BRIEF.md
# Shadowed Configuration Register Update Controller

This block keeps two host-writable configuration words on the local side and copies them into two matching registers in a remote block over a one-bit serial link. Each serial frame holds a remote register address followed by a data word. Another requester can also send frames on the same link. The block arbitrates between those frames and its own.

The block has two modes, selected by a control bit. In direct mode, a host write to either word queues a frame at once, and the frame goes out as soon as the link is free. In shadowed mode, host writes are only recorded as pending. The copy runs when software has armed a go flag and a frame-synchronous update strobe then arrives. Only the words that have pending writes are sent, the lower one first. The go flag is cleared by hardware when the copy ends, and also when there was nothing to send. A frame already on the link always finishes before the copy starts.

Top module: `cfg_shadow_ctrl`

## Requirements
- R1: After reset the link is idle (`ser_valid`, `ser_done` and `ext_gnt` are 0), both shadow words read 0, and the mode bit, go flag and pending flags read 0.
- R2: A frame drives `ser_valid` high for exactly 40 consecutive cycles and carries 8 address bits then 32 data bits, most significant bit first. Shadow word 0 uses remote address 0x20 and word 1 uses 0x21. `ser_done` is high for one cycle, in the cycle right after the last bit.
- R3: In direct mode (control bit 0 = 0), a host write to a shadow word starts a frame carrying the written value once the link is free.
- R4: In shadowed mode (control bit 0 = 1), host writes to the shadow words send no frame until an update strobe arrives while the go flag is set.
- R5: An update strobe that arrives with the go flag set and no pending word clears the go flag on the next cycle and sends no frame.
- R6: With only one word pending at the strobe, only that word is sent, and the other remote register receives nothing.
- R7: With both words pending at the strobe, word 0 (address 0x20) is sent first, then word 1 (address 0x21).
- R8: The go flag (control bit 1, set by writing 1, unchanged by writing 0) reads 1 until the last required frame completes. It reads 0 from the cycle in which that frame's `ser_done` is high.
- R9: A frame already on the link finishes before any new frame starts. While the link is idle and no shadow copy is running, an external request is granted (`ext_gnt` high for that cycle) ahead of direct-mode words. While a shadow copy is running, external requests are held off.
- R10: The host map is: address 0 is word 0, address 1 is word 1, address 2 is control (bit 0 mode, bit 1 go), and address 3 is status (bits 1:0 pending flags, bit 2 busy). A write sets a word's pending flag. The flag clears when that word's frame completes, unless the word was written again during the frame, in which case it stays set.
- R11: An update strobe while the go flag is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` (combinational) |
| upd_sync | input | 1 | Frame-synchronous update strobe |
| ext_req | input | 1 | External frame request, held until granted |
| ext_addr | input | 8 | External frame address |
| ext_data | input | 32 | External frame data |
| ext_gnt | output | 1 | External frame launched this cycle |
| ser_data | output | 1 | Serial data bit |
| ser_valid | output | 1 | Frame bit valid |
| ser_done | output | 1 | One-cycle pulse after a frame's last bit |

## Verification
Some properties are checked on every cycle by the assertions:
- a frame never starts while the link is busy;
- an external request is never granted during a shadow copy;
- a pending flag falls only when its frame completes, and the go flag falls only on a hardware clear;
- word 1 never starts ahead of a pending word 0 within a copy;
- a copy begins only on a strobe seen with go set;
- the done pulse follows the end of each frame.

Other behaviour only shows in the bench's scenarios, where a cycle-by-cycle reference model and decoded frames are compared with the outputs:
- that writes made in shadowed mode send nothing until the strobe;
- that an empty strobe sends no frame;
- the exact frame contents;
- the re-arming of a flag written during its own transfer.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_EXT  = 2'd1,
    OWN_W0   = 2'd2,
    OWN_W1   = 2'd3
  } owner_e;
endpackage

// File: rtl/cfg_shadow_tx.sv
module cfg_shadow_tx #(
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               busy,
  output logic               last,
  output logic               sdata,
  output logic               svalid,
  output logic               done
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg, shreg_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic               busy_n, done_n;

  always_comb begin
    shreg_n = shreg;
    cnt_n   = cnt;
    busy_n  = busy;
    done_n  = 1'b0;
    if (start) begin
      shreg_n = frame;
      cnt_n   = CNT_W'(FRAME_W);
      busy_n  = 1'b1;
    end else if (busy) begin
      shreg_n = {shreg[FRAME_W-2:0], 1'b0};
      cnt_n   = cnt - 1'b1;
      if (last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      shreg <= shreg_n;
      cnt   <= cnt_n;
      busy  <= busy_n;
      done  <= done_n;
    end
  end

  assign last   = busy && (cnt == CNT_W'(1));
  assign sdata  = shreg[FRAME_W-1];
  assign svalid = busy;

  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/cfg_shadow_regs.sv
module cfg_shadow_regs #(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_we,
  input  logic [1:0]             host_addr,
  input  logic [DATA_W-1:0]      host_wdata,
  output logic [DATA_W-1:0]      host_rdata,
  input  logic [1:0]             complete,
  input  logic [1:0]             inflight,
  input  logic                   go_clr,
  input  logic                   busy,
  output logic [1:0][DATA_W-1:0] shadow,
  output logic [1:0]             pend,
  output logic                   go,
  output logic                   shen
);
  localparam logic [1:0] CTRL_ADDR = 2'd2;
  localparam logic [1:0] STAT_ADDR = 2'd3;

  logic ctrl_wr;
  logic go_n, shen_n;

  assign ctrl_wr = host_we && (host_addr == CTRL_ADDR);

  for (genvar i = 0; i < 2; i++) begin : g_word
    logic wr_i, pend_n, rearm, rearm_n;
    assign wr_i = host_we && (host_addr == 2'(i));

    always_comb begin
      pend_n  = pend[i];
      rearm_n = rearm;
      if (complete[i])                rearm_n = 1'b0;
      else if (wr_i && inflight[i])   rearm_n = 1'b1;
      if (wr_i)                       pend_n  = 1'b1;
      else if (complete[i] && !rearm) pend_n  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[i] <= '0;
        pend[i]   <= 1'b0;
        rearm     <= 1'b0;
      end else begin
        if (wr_i) shadow[i] <= host_wdata;
        pend[i] <= pend_n;
        rearm   <= rearm_n;
      end
    end

    assert_pend_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[i]) |-> $past(complete[i]));
  end

  always_comb begin
    go_n   = go;
    shen_n = shen;
    if (go_clr) go_n = 1'b0;
    if (ctrl_wr) begin
      shen_n = host_wdata[0];
      if (host_wdata[1]) go_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go   <= 1'b0;
      shen <= 1'b0;
    end else begin
      go   <= go_n;
      shen <= shen_n;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      2'd0:      host_rdata = shadow[0];
      2'd1:      host_rdata = shadow[1];
      CTRL_ADDR: host_rdata[1:0] = {go, shen};
      STAT_ADDR: host_rdata[2:0] = {busy, pend};
      default:   host_rdata = '0;
    endcase
  end

  assert_go_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> $past(go_clr));
endmodule

// File: rtl/cfg_shadow_seq.sv
module cfg_shadow_seq
  import cfg_shadow_pkg::*;
#(
  parameter int                 DATA_W    = 32,
  parameter int                 RADDR_W   = 8,
  parameter logic [RADDR_W-1:0] ADDR_BASE = 8'h20,
  localparam int                FRAME_W   = RADDR_W + DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shen,
  input  logic                   go,
  input  logic                   sync,
  input  logic [1:0]             pend,
  input  logic [1:0][DATA_W-1:0] shadow,
  input  logic                   ext_req,
  input  logic [RADDR_W-1:0]     ext_addr,
  input  logic [DATA_W-1:0]      ext_data,
  input  logic                   tx_busy,
  input  logic                   tx_last,
  output logic                   launch,
  output logic [FRAME_W-1:0]     frame,
  output logic                   ext_gnt,
  output logic [1:0]             complete,
  output logic [1:0]             inflight,
  output logic                   go_clr,
  output logic                   run
);
  owner_e     owner, owner_n;
  logic [1:0] sel, sel_n, sel_left;
  logic       run_n;
  logic       launch_reg, pick;

  always_comb begin
    launch_reg = 1'b0;
    ext_gnt    = 1'b0;
    pick       = 1'b0;
    if (!tx_busy) begin
      if (run) begin
        launch_reg = |sel;
        pick       = !sel[0];
      end else if (ext_req) begin
        ext_gnt = 1'b1;
      end else if (!shen && (|pend)) begin
        launch_reg = 1'b1;
        pick       = !pend[0];
      end
    end
    launch = launch_reg || ext_gnt;
    frame  = ext_gnt ? {ext_addr, ext_data}
                     : {ADDR_BASE + RADDR_W'(pick), shadow[pick]};
  end

  assign complete[0] = tx_last && (owner == OWN_W0);
  assign complete[1] = tx_last && (owner == OWN_W1);
  assign inflight[0] = (owner == OWN_W0);
  assign inflight[1] = (owner == OWN_W1);
  assign sel_left    = sel & ~complete;

  always_comb begin
    owner_n = owner;
    if (tx_last)         owner_n = OWN_NONE;
    if (ext_gnt)         owner_n = OWN_EXT;
    else if (launch_reg) owner_n = pick ? OWN_W1 : OWN_W0;
  end

  always_comb begin
    run_n  = run;
    sel_n  = sel;
    go_clr = 1'b0;
    if (run) begin
      if (|complete) begin
        sel_n = sel_left;
        if (sel_left == 2'b00) begin
          run_n  = 1'b0;
          go_clr = 1'b1;
        end
      end
    end else if (shen && go && sync) begin
      if (pend == 2'b00) begin
        go_clr = 1'b1;
      end else begin
        run_n = 1'b1;
        sel_n = pend;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= OWN_NONE;
      sel   <= 2'b00;
      run   <= 1'b0;
    end else begin
      owner <= owner_n;
      sel   <= sel_n;
      run   <= run_n;
    end
  end

  assert_no_ext_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !ext_gnt);
  assert_low_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(inflight[1])) |-> !sel[0]);
  assert_run_needs_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(sync && go && shen));
endmodule

// File: rtl/cfg_shadow_ctrl.sv
module cfg_shadow_ctrl #(
  parameter int                 DATA_W    = 32,
  parameter int                 RADDR_W   = 8,
  parameter logic [RADDR_W-1:0] ADDR_BASE = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [1:0]         host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               upd_sync,
  input  logic               ext_req,
  input  logic [RADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0]  ext_data,
  output logic               ext_gnt,
  output logic               ser_data,
  output logic               ser_valid,
  output logic               ser_done
);
  localparam int FRAME_W = RADDR_W + DATA_W;

  logic [1:0][DATA_W-1:0] shadow;
  logic [1:0]             pend, complete, inflight;
  logic                   go, shen, go_clr, run;
  logic                   launch, tx_busy, tx_last;
  logic [FRAME_W-1:0]     frame;

  cfg_shadow_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .complete   (complete),
    .inflight   (inflight),
    .go_clr     (go_clr),
    .busy       (tx_busy || run),
    .shadow     (shadow),
    .pend       (pend),
    .go         (go),
    .shen       (shen)
  );

  cfg_shadow_seq #(
    .DATA_W    (DATA_W),
    .RADDR_W   (RADDR_W),
    .ADDR_BASE (ADDR_BASE)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .shen     (shen),
    .go       (go),
    .sync     (upd_sync),
    .pend     (pend),
    .shadow   (shadow),
    .ext_req  (ext_req),
    .ext_addr (ext_addr),
    .ext_data (ext_data),
    .tx_busy  (tx_busy),
    .tx_last  (tx_last),
    .launch   (launch),
    .frame    (frame),
    .ext_gnt  (ext_gnt),
    .complete (complete),
    .inflight (inflight),
    .go_clr   (go_clr),
    .run      (run)
  );

  cfg_shadow_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (launch),
    .frame  (frame),
    .busy   (tx_busy),
    .last   (tx_last),
    .sdata  (ser_data),
    .svalid (ser_valid),
    .done   (ser_done)
  );
endmodule

// File: tb/cfg_shadow_ctrl_bench.sv
`timescale 1ns/1ps
module cfg_shadow_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd3;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        upd_sync = 1'b0;
  logic        ext_req = 1'b0;
  logic [7:0]  ext_addr = '0;
  logic [31:0] ext_data = '0;
  logic        ext_gnt, ser_data, ser_valid, ser_done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cfg_shadow_ctrl u_cfg_shadow_ctrl (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .upd_sync(upd_sync),
    .ext_req(ext_req), .ext_addr(ext_addr), .ext_data(ext_data),
    .ext_gnt(ext_gnt), .ser_data(ser_data), .ser_valid(ser_valid),
    .ser_done(ser_done)
  );

  // Behavioural reference model
  bit [39:0] m_frame;
  int        m_left, m_own;
  bit [1:0]  m_pend, m_rearm, m_sel;
  bit        m_go, m_shen, m_run, m_done, m_ext_seen;
  bit [31:0] m_sh [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_frame = '0; m_left = 0; m_own = 0; m_pend = 0; m_rearm = 0;
      m_sel = 0; m_go = 0; m_shen = 0; m_run = 0; m_done = 0;
      m_sh[0] = 0; m_sh[1] = 0;
    end else begin
      int lreg, cmp;
      bit lext, last, goclr;
      bit [1:0] np, nr, pend_old;
      lreg = -1; lext = 0; goclr = 0; pend_old = m_pend;
      if (m_left == 0) begin
        if (m_run) lreg = m_sel[0] ? 0 : (m_sel[1] ? 1 : -1);
        else if (ext_req) lext = 1;
        else if (!m_shen && m_pend != 0) lreg = m_pend[0] ? 0 : 1;
      end
      last = (m_left == 1);
      cmp = (last && m_own >= 2) ? m_own - 2 : -1;
      m_done = last;
      np = m_pend; nr = m_rearm;
      for (int i = 0; i < 2; i++) begin
        bit wr;
        wr = host_we && host_addr == 2'(i);
        if (cmp == i) nr[i] = 0;
        else if (wr && m_own == 2 + i) nr[i] = 1;
        if (wr) np[i] = 1;
        else if (cmp == i && !m_rearm[i]) np[i] = 0;
      end
      if (m_run) begin
        if (cmp >= 0) begin
          m_sel[cmp] = 0;
          if (m_sel == 0) begin m_run = 0; goclr = 1; end
        end
      end else if (m_shen && m_go && upd_sync) begin
        if (pend_old == 0) goclr = 1;
        else begin m_run = 1; m_sel = pend_old; end
      end
      if (m_left > 0) m_left--;
      if (last) m_own = 0;
      if (lext) begin
        m_frame = {ext_addr, ext_data}; m_left = 40; m_own = 1; m_ext_seen = 1;
      end else if (lreg >= 0) begin
        m_frame = {8'h20 + 8'(lreg), m_sh[lreg]}; m_left = 40; m_own = 2 + lreg;
      end
      m_pend = np; m_rearm = nr;
      if (goclr) m_go = 0;
      if (host_we && host_addr == 2'd2) begin
        m_shen = host_wdata[0];
        if (host_wdata[1]) m_go = 1;
      end
      if (host_we && host_addr < 2) m_sh[host_addr] = host_wdata;
    end
  end

  // Per-cycle comparison and frame capture
  bit [39:0] cap;
  bit [39:0] got [$];

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit [31:0] er;
      bit eg;
      eg = (m_left == 0) && !m_run && ext_req;
      case (host_addr)
        2'd0: er = m_sh[0];
        2'd1: er = m_sh[1];
        2'd2: er = {30'd0, m_go, m_shen};
        default: er = {29'd0, (m_left > 0) || m_run, m_pend};
      endcase
      checks++;
      if (ser_valid !== (m_left > 0) || ser_done !== m_done ||
          (ser_valid && ser_data !== m_frame[m_left-1])) begin
        errors++;
        $display("FAIL R2 serial: valid=%0b done=%0b data=%0b exp valid=%0b done=%0b data=%0b",
                 ser_valid, ser_done, ser_data, m_left > 0, m_done,
                 (m_left > 0) ? m_frame[m_left-1] : 1'b0);
      end
      checks++;
      if (ext_gnt !== eg) begin
        errors++;
        $display("FAIL R9 ext_gnt: got %0b exp %0b", ext_gnt, eg);
      end
      checks++;
      if (host_rdata !== er) begin
        errors++;
        $display("FAIL R10 rdata addr %0d: got %h exp %h", host_addr, host_rdata, er);
      end
      if (ser_valid) cap = {cap[38:0], ser_data};
      if (ser_done) got.push_back(cap);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit [1:0] a, input bit [31:0] d);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0; host_addr = 2'd3;
  endtask

  task automatic sync_pulse();
    upd_sync = 1;
    @(negedge clk);
    upd_sync = 0;
  endtask

  task automatic rd(input bit [1:0] a, output bit [31:0] v);
    host_addr = a;
    #2 v = host_rdata;
    host_addr = 2'd3;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic chk_frames(input string tag, input bit [39:0] exp [$]);
    checks++;
    if (got.size() != exp.size()) begin
      errors++;
      $display("FAIL %s frame count: got %0d exp %0d", tag, got.size(), exp.size());
    end else begin
      foreach (exp[k]) if (got[k] !== exp[k]) begin
        errors++;
        $display("FAIL %s frame %0d: got %h exp %h", tag, k, got[k], exp[k]);
      end
    end
    got.delete();
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] v;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    rd(2'd0, v); chk("R1 word0", v, 0);
    rd(2'd1, v); chk("R1 word1", v, 0);
    rd(2'd2, v); chk("R1 ctrl", v, 0);
    rd(2'd3, v); chk("R1 status", v, 0);
    chk("R1 link", {ser_valid, ser_done, ext_gnt}, 0);

    // R3 direct mode, R2 frame format
    wr(2'd0, 32'hA5A5_0001);
    step(50);
    chk_frames("R3 direct", '{ {8'h20, 32'hA5A5_0001} });
    rd(2'd3, v); chk("R10 pend cleared", v, 0);

    // R9 external wins over direct word when both arrive together
    ext_addr = 8'h55; ext_data = 32'h1234_5678; ext_req = 1;
    m_ext_seen = 0;
    wr(2'd1, 32'h0BAD_F00D);
    while (!m_ext_seen) step(1);
    ext_req = 0;
    step(100);
    chk_frames("R9 ext first", '{ {8'h55, 32'h1234_5678}, {8'h21, 32'h0BAD_F00D} });

    // R4 shadowed mode holds writes
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h1111_0000);
    wr(2'd1, 32'h2222_0000);
    step(60);
    chk_frames("R4 held", '{});
    rd(2'd3, v); chk("R10 both pending", v, 32'h3);
    // R11 strobe without go
    sync_pulse(); step(60);
    chk_frames("R11 ignored", '{});
    // R7 both pending, R8 go clear
    wr(2'd2, 32'h3);
    rd(2'd2, v); chk("R8 go set", v, 32'h3);
    sync_pulse();
    step(45);
    rd(2'd2, v); chk("R8 go held mid-copy", v, 32'h3);
    step(60);
    chk_frames("R7 order", '{ {8'h20, 32'h1111_0000}, {8'h21, 32'h2222_0000} });
    rd(2'd2, v); chk("R8 go cleared", v, 32'h1);

    // R6 only one pending
    wr(2'd1, 32'h3333_0001);
    wr(2'd2, 32'h3);
    sync_pulse(); step(60);
    chk_frames("R6 single", '{ {8'h21, 32'h3333_0001} });
    rd(2'd2, v); chk("R8 go after single", v, 32'h1);

    // R5 empty strobe
    wr(2'd2, 32'h3);
    sync_pulse();
    rd(2'd2, v); chk("R5 go cleared", v, 32'h1);
    step(50);
    chk_frames("R5 nothing sent", '{});

    // R9 ongoing external frame finishes first, then ext held off during copy
    wr(2'd0, 32'h4444_0004);
    wr(2'd2, 32'h3);
    ext_addr = 8'h66; ext_data = 32'hCAFE_0001; ext_req = 1; m_ext_seen = 0;
    while (!m_ext_seen) step(1);
    ext_req = 0;
    step(5);
    sync_pulse();
    step(2);
    ext_addr = 8'h77; ext_data = 32'hCAFE_0002; ext_req = 1; m_ext_seen = 0;
    while (!m_ext_seen) step(1);
    ext_req = 0;
    step(50);
    chk_frames("R9 wait and hold", '{ {8'h66, 32'hCAFE_0001}, {8'h20, 32'h4444_0004},
                                      {8'h77, 32'hCAFE_0002} });

    // R10 re-arm by write during transfer
    wr(2'd0, 32'h5555_0005);
    wr(2'd2, 32'h3);
    sync_pulse();
    step(10);
    wr(2'd0, 32'h6666_0006);
    step(40);
    rd(2'd3, v); chk("R10 re-armed", v, 32'h1);
    rd(2'd2, v); chk("R8 go after re-arm", v, 32'h1);
    chk_frames("R10 first value", '{ {8'h20, 32'h5555_0005} });
    wr(2'd2, 32'h3);
    sync_pulse(); step(50);
    chk_frames("R10 new value", '{ {8'h20, 32'h6666_0006} });
    rd(2'd3, v); chk("R10 clear", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule